// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Sequencer

This block drives the time-multiplexed refresh of a dot-matrix character panel. It steps through the common rows of the panel one at a time. The number of active rows is set by a duty selection: 8, 11 or 16 rows. It holds each row for a fixed number of oscillator ticks. During each row it fetches the 40 pixel bits of the following row from an external row store, then sends them serially on a data pin with a shift clock. At the next row boundary it pulses a latch clock, so that the cascaded segment drivers show the bits they have received while the new common row is selected.

The block also produces the drive polarity signal, which turns the panel drive into an AC waveform. One option makes the polarity invert once per frame. The other option makes it invert at every row boundary. In both cases the polarity edge falls on the same clock edge as the rising latch clock.

A shifter state machine sequences the work inside each row. Its states are LATCH, FETCH, SHIFT and DONE, with these transitions:
- LATCH to FETCH, after the latch pulse has run its ticks.
- FETCH to SHIFT, on the cycle the row data is acknowledged.
- SHIFT to DONE, after the last bit period.
- Any state to LATCH, at a row boundary. This transition has priority over all others.

The reset state is FETCH.

Top module: `lcd_scan_seq`

## Requirements
- R1: The duty code `duty_sel` chooses the number of active rows: 2'b00 gives 8 rows, 2'b01 gives 11 rows, and 2'b10 or 2'b11 gives 16 rows. Exactly one bit of `com_sel` is high, and `com_sel[i]` marks row i. Rows advance 0, 1, …, N-1 and then wrap to 0. Bits at or above N stay low.
- R2: A row lasts 400 ticks of `osc_tick` for 8 or 11 rows, and 200 ticks for 16 rows. The scan state changes only on cycles where `osc_tick` is high. After n ticks since reset, the active row is (n / period) mod N.
- R3: While reset is applied, the outputs are:
  - `com_sel` = 1
  - `drive_pol` = 0
  - `seg_latch_clk` = 0
  - `seg_shift_clk` = 0
  - `seg_data` = 0
  - `row_req` = 1
  - `req_row` = 1
- R4: `row_req` stays high while the block waits for data. While it is high, `req_row` shows the index of the row that follows the active row. `row_bits` is captured on the clock edge where `row_ack` is high, and `row_req` falls after that edge.
- R5: The 40 captured bits are sent on `seg_data` with bit 0 first. Each bit takes 4 ticks: `seg_shift_clk` is low for 2 ticks and then high for 2 ticks. `seg_data` changes only while the shift clock is low. The receiver samples on the rising edge.
- R6: `seg_latch_clk` is high for the first 2 ticks of every row except row 0 of the first frame after reset. The 40 bits sent before each latch pulse are the row data of the row that becomes active at that pulse. The shift clock stays low while the latch clock is high or a fetch is pending.
- R7: With `wave_b` = 0, `drive_pol` inverts only at the row boundary that enters row 0.
- R8: With `wave_b` = 1, `drive_pol` inverts at every row boundary.
- R9: Every edge of `drive_pol` falls on the same clock edge as a rising edge of `seg_latch_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable that marks each oscillator tick |
| duty_sel | input | 2 | Duty code (8, 11 or 16 active rows) |
| wave_b | input | 1 | 0: polarity inverts once per frame; 1: polarity inverts every row |
| row_req | output | 1 | Request for the pixel bits of the next row |
| req_row | output | 4 | Index of the row being requested |
| row_ack | input | 1 | Response strobe; `row_bits` is valid on this cycle |
| row_bits | input | 40 | Pixel bits for the requested row; 1 means the pixel is selected |
| com_sel | output | 16 | One-hot select of the active common row |
| seg_data | output | 1 | Serial pixel data to the segment drivers |
| seg_shift_clk | output | 1 | Shift clock for `seg_data` |
| seg_latch_clk | output | 1 | Latch pulse at each row boundary |
| drive_pol | output | 1 | AC drive polarity |

## Verification
An error in the row counter or the tick counter shows on `com_sel` and `seg_latch_clk` at the first boundary that follows. The bench predicts both outputs on every cycle from the tick count, so such an error is caught within one row period. A polarity register with the wrong rule shows as a wrong `drive_pol` level at the row boundary where it should or should not invert. A fault in the shifter's bit counter, phase counter or shift register reaches the port as a bit vector of the wrong length or content. The bench compares that vector against its own pattern at the next latch pulse, so the fault surfaces within the same row.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        SH_LATCH = 2'd0,
        SH_FETCH = 2'd1,
        SH_SHIFT = 2'd2,
        SH_DONE  = 2'd3
    } sh_state_e;

    localparam logic [1:0] DUTY_ONE_LINE  = 2'b00;
    localparam logic [1:0] DUTY_TALL_FONT = 2'b01;

endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
    parameter int LONG_TICKS  = 400,
    parameter int SHORT_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic short_row,
    output logic wrap
);
    localparam int TW = $clog2(LONG_TICKS);

    logic [TW-1:0] tcnt;
    logic [TW-1:0] last_cnt;

    always_comb begin
        last_cnt = short_row ? TW'(SHORT_TICKS - 1) : TW'(LONG_TICKS - 1);
    end

    assign wrap = tick && (tcnt >= last_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= wrap ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
    parameter int COM_ROWS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wrap,
    input  logic [$clog2(COM_ROWS+1)-1:0]       active_rows,
    input  logic                                wave_b,
    output logic [COM_ROWS-1:0]                 com_sel,
    output logic                                polar,
    output logic [$clog2(COM_ROWS)-1:0]         next_row
);
    localparam int RW = $clog2(COM_ROWS);
    localparam int CW = $clog2(COM_ROWS + 1);

    logic [RW-1:0] row;
    logic          at_last;

    always_comb begin
        at_last  = (CW'(row) >= (active_rows - CW'(1)));
        next_row = at_last ? '0 : row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row   <= '0;
            polar <= 1'b0;
        end else if (wrap) begin
            row <= next_row;
            if (wave_b || (next_row == '0)) begin
                polar <= ~polar;
            end
        end
    end

    for (genvar g = 0; g < COM_ROWS; g++) begin : g_com
        assign com_sel[g] = (row == RW'(g)) && (CW'(g) < active_rows);
    end
endmodule

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter
    import lcd_scan_pkg::*;
#(
    parameter int SEG_BITS    = 40,
    parameter int SHIFT_DIV   = 4,
    parameter int LATCH_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wrap,
    input  logic                row_ack,
    input  logic [SEG_BITS-1:0] row_bits,
    output logic                row_req,
    output logic                sd,
    output logic                shclk,
    output logic                lclk
);
    localparam int BW = $clog2(SEG_BITS + 1);
    localparam int PW = $clog2(SHIFT_DIV);
    localparam int LW = $clog2(LATCH_TICKS + 1);

    sh_state_e           state, state_n;
    logic [SEG_BITS-1:0] shreg;
    logic [BW-1:0]       bitcnt;
    logic [PW-1:0]       phase;
    logic [LW-1:0]       lcnt;
    logic                bit_end;

    assign bit_end = tick && (phase == PW'(SHIFT_DIV - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SH_FETCH;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        if (wrap) begin
            state_n = SH_LATCH;
        end else begin
            unique case (state)
                SH_LATCH: if (tick && lcnt == LW'(LATCH_TICKS - 1)) state_n = SH_FETCH;
                SH_FETCH: if (row_ack) state_n = SH_SHIFT;
                SH_SHIFT: if (bit_end && bitcnt == BW'(SEG_BITS - 1)) state_n = SH_DONE;
                SH_DONE:  state_n = SH_DONE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            phase  <= '0;
            lcnt   <= '0;
        end else begin
            if (wrap) begin
                lcnt <= '0;
            end else if (state == SH_LATCH && tick) begin
                lcnt <= lcnt + 1'b1;
            end

            if (state == SH_FETCH && row_ack && !wrap) begin
                shreg  <= row_bits;
                bitcnt <= '0;
                phase  <= '0;
            end else if (state == SH_SHIFT && tick) begin
                if (bit_end) begin
                    phase  <= '0;
                    shreg  <= shreg >> 1;
                    bitcnt <= bitcnt + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        row_req = (state == SH_FETCH);
        lclk    = (state == SH_LATCH);
        shclk   = (state == SH_SHIFT) && (phase >= PW'(SHIFT_DIV / 2));
        sd      = (state == SH_SHIFT) ? shreg[0] : 1'b0;
    end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int COM_ROWS      = 16,
    parameter int ROWS_ONE_LINE = 8,
    parameter int ROWS_TALL     = 11,
    parameter int SEG_BITS      = 40,
    parameter int LONG_TICKS    = 400,
    parameter int SHORT_TICKS   = 200,
    parameter int SHIFT_DIV     = 4,
    parameter int LATCH_TICKS   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        osc_tick,
    input  logic [1:0]                  duty_sel,
    input  logic                        wave_b,
    output logic                        row_req,
    output logic [$clog2(COM_ROWS)-1:0] req_row,
    input  logic                        row_ack,
    input  logic [SEG_BITS-1:0]         row_bits,
    output logic [COM_ROWS-1:0]         com_sel,
    output logic                        seg_data,
    output logic                        seg_shift_clk,
    output logic                        seg_latch_clk,
    output logic                        drive_pol
);
    localparam int CW = $clog2(COM_ROWS + 1);

    logic [CW-1:0] active_rows;
    logic          short_row;
    logic          wrap;

    always_comb begin
        unique case (duty_sel)
            DUTY_ONE_LINE:  begin active_rows = CW'(ROWS_ONE_LINE); short_row = 1'b0; end
            DUTY_TALL_FONT: begin active_rows = CW'(ROWS_TALL);     short_row = 1'b0; end
            default:        begin active_rows = CW'(COM_ROWS);      short_row = 1'b1; end
        endcase
    end

    lcd_row_timer #(
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .short_row(short_row),
        .wrap     (wrap)
    );

    lcd_com_scan #(
        .COM_ROWS(COM_ROWS)
    ) u_com (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .active_rows(active_rows),
        .wave_b     (wave_b),
        .com_sel    (com_sel),
        .polar      (drive_pol),
        .next_row   (req_row)
    );

    lcd_seg_shifter #(
        .SEG_BITS   (SEG_BITS),
        .SHIFT_DIV  (SHIFT_DIV),
        .LATCH_TICKS(LATCH_TICKS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (osc_tick),
        .wrap    (wrap),
        .row_ack (row_ack),
        .row_bits(row_bits),
        .row_req (row_req),
        .sd      (seg_data),
        .shclk   (seg_shift_clk),
        .lclk    (seg_latch_clk)
    );
endmodule

// File: rtl/lcd_scan_seq_chk.sv
module lcd_scan_seq_chk #(
    parameter int COM_ROWS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          duty_sel,
    input logic                wave_b,
    input logic                row_req,
    input logic [COM_ROWS-1:0] com_sel,
    input logic                seg_data,
    input logic                seg_shift_clk,
    input logic                seg_latch_clk,
    input logic                drive_pol
);
    a_r1_single_com: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_sel) <= 1);

    a_r1_high_rows_off: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == 2'b00) |-> ((com_sel >> 8) == '0));

    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_shift_clk && $past(seg_shift_clk)) |-> $stable(seg_data));

    a_r6_latch_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        seg_latch_clk |-> !seg_shift_clk);

    a_r4_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        row_req |-> (!seg_shift_clk && !seg_latch_clk));

    a_r8_every_row: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wave_b) && $rose(seg_latch_clk)) |-> !$stable(drive_pol));

    a_r9_pol_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_pol) |-> $rose(seg_latch_clk));
endmodule

bind lcd_scan_seq lcd_scan_seq_chk #(.COM_ROWS(COM_ROWS)) u_chk (.*);

// File: tb/lcd_scan_seq_tb.sv
module lcd_scan_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        osc_tick;
    logic [1:0]  duty_sel;
    logic        wave_b;
    logic        row_req;
    logic [3:0]  req_row;
    logic        row_ack;
    logic [39:0] row_bits;
    logic [15:0] com_sel;
    logic        seg_data;
    logic        seg_shift_clk;
    logic        seg_latch_clk;
    logic        drive_pol;

    always #4 clk = ~clk;

    lcd_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .duty_sel(duty_sel),
        .wave_b(wave_b), .row_req(row_req), .req_row(req_row), .row_ack(row_ack),
        .row_bits(row_bits), .com_sel(com_sel), .seg_data(seg_data),
        .seg_shift_clk(seg_shift_clk), .seg_latch_clk(seg_latch_clk),
        .drive_pol(drive_pol)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit run   = 0;
    int nrows = 8;
    int period = 400;
    int ack_lat = 1;
    int n = 0;
    int acnt = 0;
    int bcnt = 0;
    int hcnt = 0;
    logic [39:0] vec = '0;
    logic prev_sh = 0, prev_lat = 0, prev_sd = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] pat(input int r);
        logic [39:0] v;
        v = {36'd0, 4'(r)} * 40'd2654435761;
        return v ^ 40'hA55A0FF0C3;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // tick on every other rising edge
    initial osc_tick = 1'b0;
    always @(negedge clk) osc_tick <= ~osc_tick;

    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else if (osc_tick) n <= n + 1;
    end

    // row store responder; also checks the requested index (R4)
    always @(negedge clk) begin
        if (!rst_n) begin
            row_ack = 1'b0;
            acnt = 0;
        end else if (row_ack) begin
            row_ack = 1'b0;
        end else if (row_req) begin
            if (acnt >= ack_lat) begin
                chk(int'(req_row) == ((n / period) + 1) % nrows, "R4 req_row",
                    req_row, ((n / period) + 1) % nrows);
                row_bits = pat(int'(req_row));
                row_ack = 1'b1;
                acnt = 0;
            end else begin
                acnt++;
            end
        end
    end

    // port-level checker
    always @(negedge clk) begin
        if (run && rst_n) begin
            int erow;
            logic [15:0] ecom;
            logic epol, elat;
            erow = (n / period) % nrows;
            ecom = 16'(1) << erow;
            chk(com_sel == ecom, "R1 com_sel", com_sel, ecom);
            if (wave_b) begin
                epol = ((n / period) % 2) != 0;
                chk(drive_pol == epol, "R8 drive_pol", drive_pol, epol);
            end else begin
                epol = ((n / (period * nrows)) % 2) != 0;
                chk(drive_pol == epol, "R7 drive_pol", drive_pol, epol);
            end
            elat = (n >= period) && ((n % period) < 2);
            chk(seg_latch_clk == elat, "R2 R6 latch timing", seg_latch_clk, elat);

            if (seg_shift_clk && !prev_sh) begin
                if (bcnt < 40) vec[bcnt] = seg_data;
                bcnt++;
                hcnt = 1;
            end else if (seg_shift_clk && prev_sh) begin
                chk(seg_data == prev_sd, "R5 data stable", seg_data, prev_sd);
                hcnt++;
            end else if (!seg_shift_clk && prev_sh) begin
                chk(hcnt == 4, "R5 high width", hcnt, 4);
            end

            if (seg_latch_clk && !prev_lat) begin
                chk(bcnt == 40, "R5 bit count", bcnt, 40);
                chk(vec == pat(erow), "R6 latched row data", vec, pat(erow));
                bcnt = 0;
                vec = '0;
            end
            prev_sh  = seg_shift_clk;
            prev_lat = seg_latch_clk;
            prev_sd  = seg_data;
        end
    end

    task automatic run_cfg(input logic [1:0] d, input logic w, input int lat);
        int cycles;
        @(negedge clk);
        run = 0;
        rst_n = 1'b0;
        duty_sel = d;
        wave_b = w;
        nrows = (d == 2'b00) ? 8 : (d == 2'b01) ? 11 : 16;
        period = (d[1]) ? 200 : 400;
        ack_lat = lat;
        repeat (3) @(negedge clk);
        chk(com_sel == 16'h0001, "R3 com_sel", com_sel, 1);
        chk(drive_pol == 1'b0, "R3 drive_pol", drive_pol, 0);
        chk(seg_latch_clk == 1'b0, "R3 latch", seg_latch_clk, 0);
        chk(seg_shift_clk == 1'b0, "R3 shift", seg_shift_clk, 0);
        chk(seg_data == 1'b0, "R3 data", seg_data, 0);
        chk(row_req == 1'b1, "R3 row_req", row_req, 1);
        chk(req_row == 4'd1, "R3 req_row", req_row, 1);
        bcnt = 0; hcnt = 0; vec = '0;
        prev_sh = 0; prev_lat = 0; prev_sd = 0;
        rst_n = 1'b1;
        run = 1;
        cycles = 2 * (2 * period * nrows + period + 8);
        repeat (cycles) @(negedge clk);
        run = 0;
    endtask

    initial begin
        rst_n = 1'b0;
        duty_sel = 2'b00;
        wave_b = 1'b0;
        row_ack = 1'b0;
        row_bits = '0;
        run_cfg(2'b00, 1'b0, 1);
        run_cfg(2'b01, 1'b0, 3);
        run_cfg(2'b10, 1'b0, 2);
        run_cfg(2'b00, 1'b1, 5);
        run_cfg(2'b01, 1'b1, 1);
        run_cfg(2'b10, 1'b1, 4);
        run_cfg(2'b11, 1'b1, 2);
        finish_run();
    end

    initial begin
        #(8 * 195000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end
endmodule